// File: doc/BRIEF.md
# Bus and Address Fault Exception Sequencer

This block sits inside a 16-bit processor core and takes over when a memory access goes wrong. Two faults start it. The first is an external bus-error signal. The second is an address error that the block raises itself when the core tries to access a word or longword operand at an odd address, or fetches an instruction from an odd address. When a fault is accepted, the block aborts the bus cycle in flight in that same cycle. It then records the context and switches the status register to supervisor mode with tracing turned off.

Next it pushes a seven-word fault frame onto the supervisor stack through a simple one-word-per-cycle write port. After that it reads the handler address from the vector table, high word first. It presents the new program counter, status register and stack pointer to the core for one cycle.

A second fault is fatal if it arrives while the core is already handling a group-0 exception (reset, bus error or address error), or while the block's own stack and vector accesses are running. The block then halts, makes no further memory accesses, and waits for reset.

Top module: `fault_seq`

## Requirements
- R1: An address error is raised when `acc_valid_i` is high, `acc_addr_i[0]` is 1, and either `acc_wide_i` (word or longword) or `acc_fetch_i` is high. Byte accesses at odd addresses and all accesses at even addresses raise no address error.
- R2: `abort_o` is high in the same cycle in which a fault is accepted in the idle state. It is also high in any cycle where `bus_err_i` hits one of the block's own memory accesses.
- R3: Starting one cycle after a fault is accepted, seven writes go out on seven consecutive cycles. Each write is to the address 2 below the previous one, and the first is to `ssp_i - 2`. The words written are, in order: saved PC bits 15:0, saved PC bits 31:16, the status register as it was on entry, the instruction word, faulting address bits 15:0, faulting address bits 31:16, and the access-information word.
- R4: The access-information word is laid out as follows. Bit 4 is the read flag (1 means read). Bit 3 is the not-instruction flag. Bits 2:0 hold the function code. All other bits are zero.
- R5: `act_i` encodes the activity: 0 normal, 1 group 0, 2 group 1, 3 group 2. The not-instruction flag is 1 for group 1 and 0 for normal and group 2 activity.
- R6: The saved PC is `pc_i + pc_off_i`. When `exc_last_i` is high, meaning the fault hit the vector read or first handler fetch of another exception, the saved PC is `exc_vec_i` instead.
- R7: After the frame, the block makes two reads, at vector address `4 * n` and then `4 * n + 2`. The vector number n is 2 for a bus error and 3 for an address error. One cycle after the second read, `newpc_valid_o` pulses for one cycle. During that pulse, `newpc_o` is {first word, second word}, `sr_o` is the entry status register with bit 13 (supervisor) set and bit 15 (trace) cleared, and `sp_o` is `ssp_i - 14`.
- R8: When a bus error and an address error occur in the same cycle, the fault is treated as an address error and uses vector 3.
- R9: If a fault is accepted while `act_i` is 1, or if `bus_err_i` is high during one of the block's own memory accesses, `halt_o` goes high in the next cycle. It stays high with no memory access until `rst_n` is asserted.
- R10: If a fault is accepted while `ssp_i` is odd, the block halts as in R9 instead of writing to an odd stack address.
- R11: While the block is busy, the `acc_*` inputs are ignored. Outside a fault sequence, the block makes no memory access and does not pulse `newpc_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way out of halt |
| bus_err_i | input | 1 | External bus error on the current access |
| acc_valid_i | input | 1 | The core has an access in progress |
| acc_addr_i | input | 32 | Address of the current access |
| acc_wide_i | input | 1 | Access is a word or longword |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_read_i | input | 1 | Access is a read |
| acc_fc_i | input | 3 | Function code of the access |
| act_i | input | 2 | Processor activity (0 normal, 1 group 0, 2 group 1, 3 group 2) |
| pc_i | input | 32 | Current program counter |
| pc_off_i | input | 4 | Byte offset added to the PC for the saved value |
| sr_i | input | 16 | Current status register |
| ir_i | input | 16 | First word of the instruction being processed |
| exc_last_i | input | 1 | Core is in the last step of another exception |
| exc_vec_i | input | 32 | Vector address of that exception |
| ssp_i | input | 32 | Supervisor stack pointer |
| mem_wr_o | output | 1 | Word write strobe |
| mem_rd_o | output | 1 | Word read strobe |
| mem_addr_o | output | 32 | Byte address of the word access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid in the cycle the read is issued |
| abort_o | output | 1 | Abort the bus cycle in flight |
| busy_o | output | 1 | Sequence in progress |
| halt_o | output | 1 | Double fault; halted |
| newpc_valid_o | output | 1 | One-cycle pulse with the handler context |
| newpc_o | output | 32 | Handler address |
| sr_o | output | 16 | Status register for the handler |
| sp_o | output | 32 | Stack pointer after the frame |

## Verification
The abort flag is combinational, so the bench checks it 1 ns after driving the fault, before the accepting edge. The seven frame writes are due on cycles 1 to 7 after that edge. The two vector reads are due on cycles 8 and 9, and the new-PC pulse on cycle 10. `halt_o` is due on the cycle after a fatal fault.

The reference model turns every accepted fault into a queue holding one expected entry per cycle. The bench pops one entry at each falling edge and compares it, so every output is checked in exactly the cycle the model predicts. When the queue is empty, the bench checks for a quiet port instead.

// File: rtl/fault_pkg.sv
package fault_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned FC_W   = 3;
  parameter int unsigned SR_TRACE = 15;
  parameter int unsigned SR_SUPER = 13;
  parameter int unsigned INFO_RD  = 4;
  parameter int unsigned INFO_NI  = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_VHI, ST_VLO, ST_DONE, ST_HALT
  } state_t;

  localparam logic [1:0] ACT_NORM = 2'd0;
  localparam logic [1:0] ACT_GRP0 = 2'd1;
  localparam logic [1:0] ACT_GRP1 = 2'd2;
  localparam logic [1:0] ACT_GRP2 = 2'd3;

  function automatic word_t info_word(logic rd, logic ni, logic [FC_W-1:0] fc);
    word_t w;
    w = '0;
    w[INFO_RD] = rd;
    w[INFO_NI] = ni;
    w[FC_W-1:0] = fc;
    return w;
  endfunction

  function automatic word_t handler_sr(word_t sr);
    word_t r;
    r = sr;
    r[SR_TRACE] = 1'b0;
    r[SR_SUPER] = 1'b1;
    return r;
  endfunction

  function automatic addr_t vec_addr(int unsigned n);
    return addr_t'(n) << 2;
  endfunction

  function automatic word_t frame_word(int unsigned k, addr_t pc, word_t sr,
                                       word_t ir, addr_t fa, word_t info);
    case (k)
      0: return pc[WORD_W-1:0];
      1: return pc[ADDR_W-1:WORD_W];
      2: return sr;
      3: return ir;
      4: return fa[WORD_W-1:0];
      5: return fa[ADDR_W-1:WORD_W];
      default: return info;
    endcase
  endfunction
endpackage

// File: rtl/fault_detect.sv
module fault_detect (
  input  logic bus_err_i,
  input  logic acc_valid_i,
  input  logic acc_odd_i,
  input  logic acc_wide_i,
  input  logic acc_fetch_i,
  output logic adr_err_o,
  output logic any_err_o
);
  always_comb begin
    adr_err_o = acc_valid_i && acc_odd_i && (acc_wide_i || acc_fetch_i);
    any_err_o = adr_err_o || bus_err_i;
  end
endmodule

// File: rtl/frame_mux.sv
module frame_mux import fault_pkg::*; #(
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  input  addr_t            pc_i,
  input  word_t            sr_i,
  input  word_t            ir_i,
  input  addr_t            fa_i,
  input  word_t            info_i,
  output word_t            word_o
);
  always_comb word_o = frame_word(int'(idx_i), pc_i, sr_i, ir_i, fa_i, info_i);
endmodule

// File: rtl/fault_seq.sv
module fault_seq import fault_pkg::*; #(
  parameter int unsigned BUS_VEC = 2,
  parameter int unsigned ADR_VEC = 3,
  parameter int unsigned OFF_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_err_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_wide_i,
  input  logic              acc_fetch_i,
  input  logic              acc_read_i,
  input  logic [FC_W-1:0]   acc_fc_i,
  input  logic [1:0]        act_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  pc_off_i,
  input  logic [WORD_W-1:0] sr_i,
  input  logic [WORD_W-1:0] ir_i,
  input  logic              exc_last_i,
  input  logic [ADDR_W-1:0] exc_vec_i,
  input  logic [ADDR_W-1:0] ssp_i,
  output logic              mem_wr_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              abort_o,
  output logic              busy_o,
  output logic              halt_o,
  output logic              newpc_valid_o,
  output logic [ADDR_W-1:0] newpc_o,
  output logic [WORD_W-1:0] sr_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam int unsigned FRAME_N = 7;
  localparam int unsigned IDX_W   = $clog2(FRAME_N);
  localparam addr_t       STEP    = addr_t'(WORD_W / 8);

  state_t            st;
  logic [IDX_W-1:0]  idx;
  addr_t             sp_r, pc_r, fa_r, vbase_r, newpc_r;
  word_t             sr_r, ir_r, info_r, vhi_r, push_word;

  logic adr_err, any_err;
  logic in_idle, on_bus, fault_take, dbl_fault, frame_last;

  fault_detect u_det (
    .bus_err_i   (bus_err_i),
    .acc_valid_i (acc_valid_i),
    .acc_odd_i   (acc_addr_i[0]),
    .acc_wide_i  (acc_wide_i),
    .acc_fetch_i (acc_fetch_i),
    .adr_err_o   (adr_err),
    .any_err_o   (any_err)
  );

  frame_mux #(.IDX_W(IDX_W)) u_frame (
    .idx_i  (idx),
    .pc_i   (pc_r),
    .sr_i   (sr_r),
    .ir_i   (ir_r),
    .fa_i   (fa_r),
    .info_i (info_r),
    .word_o (push_word)
  );

  assign in_idle    = (st == ST_IDLE);
  assign on_bus     = (st == ST_PUSH) || (st == ST_VHI) || (st == ST_VLO);
  assign fault_take = in_idle && any_err;
  assign dbl_fault  = (fault_take && ((act_i == ACT_GRP0) || ssp_i[0]))
                   || (on_bus && bus_err_i);
  assign frame_last = (st == ST_PUSH) && (idx == IDX_W'(FRAME_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      sp_r    <= '0;
      pc_r    <= '0;
      fa_r    <= '0;
      vbase_r <= '0;
      newpc_r <= '0;
      sr_r    <= '0;
      ir_r    <= '0;
      info_r  <= '0;
      vhi_r   <= '0;
    end else if (dbl_fault) begin
      st <= ST_HALT;
    end else begin
      case (st)
        ST_IDLE: if (fault_take) begin
          st      <= ST_PUSH;
          idx     <= '0;
          sp_r    <= ssp_i;
          pc_r    <= exc_last_i ? exc_vec_i : (pc_i + addr_t'(pc_off_i));
          sr_r    <= sr_i;
          ir_r    <= ir_i;
          fa_r    <= acc_addr_i;
          info_r  <= info_word(acc_read_i, act_i == ACT_GRP1, acc_fc_i);
          vbase_r <= vec_addr(adr_err ? ADR_VEC : BUS_VEC);
        end
        ST_PUSH: begin
          sp_r <= sp_r - STEP;
          idx  <= idx + 1'b1;
          if (frame_last) st <= ST_VHI;
        end
        ST_VHI: begin
          vhi_r <= mem_rdata_i;
          st    <= ST_VLO;
        end
        ST_VLO: begin
          newpc_r <= {vhi_r, mem_rdata_i};
          st      <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    mem_wr_o    = (st == ST_PUSH);
    mem_rd_o    = (st == ST_VHI) || (st == ST_VLO);
    mem_wdata_o = mem_wr_o ? push_word : '0;
    case (st)
      ST_PUSH: mem_addr_o = sp_r - STEP;
      ST_VHI:  mem_addr_o = vbase_r;
      ST_VLO:  mem_addr_o = vbase_r + STEP;
      default: mem_addr_o = '0;
    endcase
  end

  assign abort_o       = fault_take || (on_bus && bus_err_i);
  assign busy_o        = !in_idle && (st != ST_HALT);
  assign halt_o        = (st == ST_HALT);
  assign newpc_valid_o = (st == ST_DONE);
  assign newpc_o       = newpc_r;
  assign sr_o          = handler_sr(sr_r);
  assign sp_o          = sp_r;
endmodule

// File: rtl/fault_seq_chk.sv
module fault_seq_chk import fault_pkg::*; #(
  parameter int unsigned BUS_VEC = 2,
  parameter int unsigned ADR_VEC = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_wr_o,
  input logic        mem_rd_o,
  input addr_t       mem_addr_o,
  input logic        halt_o,
  input logic        newpc_valid_o,
  input word_t       sr_o,
  input logic        abort_o,
  input logic        fault_take,
  input logic        dbl_fault
);
  AST_ABORT_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |-> abort_o); // R2
  AST_TAKE_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take && !dbl_fault |=> mem_wr_o); // R3
  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o && $past(mem_wr_o) |-> mem_addr_o == $past(mem_addr_o) - addr_t'(2)); // R3
  AST_ONE_PORT_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_o && mem_rd_o)); // R3
  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> ((mem_addr_o >> 2) == addr_t'(BUS_VEC)) || ((mem_addr_o >> 2) == addr_t'(ADR_VEC))); // R7
  AST_HANDLER_SR: assert property (@(posedge clk) disable iff (!rst_n)
    newpc_valid_o |-> sr_o[SR_SUPER] && !sr_o[SR_TRACE]); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !mem_wr_o && !mem_rd_o && !newpc_valid_o); // R9
  AST_STACK_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> !mem_addr_o[0]); // R10
endmodule

bind fault_seq fault_seq_chk #(.BUS_VEC(BUS_VEC), .ADR_VEC(ADR_VEC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_wr_o      (mem_wr_o),
  .mem_rd_o      (mem_rd_o),
  .mem_addr_o    (mem_addr_o),
  .halt_o        (halt_o),
  .newpc_valid_o (newpc_valid_o),
  .sr_o          (sr_o),
  .abort_o       (abort_o),
  .fault_take    (fault_take),
  .dbl_fault     (dbl_fault)
);

// File: tb/fault_seq_tb.sv
`timescale 1ns/1ps
module fault_seq_tb;
  logic clk = 0, rst_n = 0;
  logic bus_err = 0, acc_valid = 0, acc_wide = 0, acc_fetch = 0, acc_read = 0;
  logic [31:0] acc_addr = 0, pc = 0, exc_vec = 0, ssp = 0;
  logic [2:0] acc_fc = 0;
  logic [1:0] act = 0;
  logic [3:0] pc_off = 0;
  logic [15:0] sr = 0, ir = 0, rdata;
  logic exc_last = 0;
  logic mem_wr_o, mem_rd_o, abort_o, busy_o, halt_o, newpc_valid_o;
  logic [31:0] mem_addr_o, newpc_o, sp_o;
  logic [15:0] mem_wdata_o, sr_o;

  always #2 clk = ~clk;

  function automatic logic [15:0] table_word(logic [31:0] a);
    return 16'hA000 + a[15:0];
  endfunction
  assign rdata = mem_rd_o ? table_word(mem_addr_o) : 16'h0;

  fault_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_err_i(bus_err), .acc_valid_i(acc_valid),
    .acc_addr_i(acc_addr), .acc_wide_i(acc_wide), .acc_fetch_i(acc_fetch),
    .acc_read_i(acc_read), .acc_fc_i(acc_fc), .act_i(act), .pc_i(pc),
    .pc_off_i(pc_off), .sr_i(sr), .ir_i(ir), .exc_last_i(exc_last),
    .exc_vec_i(exc_vec), .ssp_i(ssp), .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(rdata),
    .abort_o(abort_o), .busy_o(busy_o), .halt_o(halt_o),
    .newpc_valid_o(newpc_valid_o), .newpc_o(newpc_o), .sr_o(sr_o), .sp_o(sp_o)
  );

  int n_chk = 0, n_bad = 0;
  int kq[$];
  logic [31:0] aq[$], dq[$], xq[$], yq[$];
  string tq[$];
  bit exp_halt = 0, pend = 0;

  task automatic chk(bit ok, string req, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic expect_ev(int k, logic [31:0] a, logic [31:0] d,
                           logic [31:0] x, logic [31:0] y, string t);
    kq.push_back(k); aq.push_back(a); dq.push_back(d);
    xq.push_back(x); yq.push_back(y); tq.push_back(t);
  endtask

  task automatic check_cycle();
    int k; logic [31:0] a, d, x, y; string t;
    if (pend) begin
      pend = 0; exp_halt = 1;
      kq.delete(); aq.delete(); dq.delete(); xq.delete(); yq.delete(); tq.delete();
    end
    if (exp_halt) begin
      chk(halt_o === 1'b1, "R9 halt held", halt_o, 1);
      chk(!mem_wr_o && !mem_rd_o, "R9 no access while halted", {mem_wr_o, mem_rd_o}, 0);
    end else if (kq.size() > 0) begin
      k = kq.pop_front(); a = aq.pop_front(); d = dq.pop_front();
      x = xq.pop_front(); y = yq.pop_front(); t = tq.pop_front();
      if (k == 0) begin
        chk(mem_wr_o === 1'b1 && mem_addr_o === a, "R3 write address", mem_addr_o, a);
        chk(mem_wdata_o === d[15:0], t, mem_wdata_o, d);
      end else if (k == 1) begin
        chk(mem_rd_o === 1'b1 && mem_addr_o === a, t, mem_addr_o, a);
      end else begin
        chk(newpc_valid_o === 1'b1 && newpc_o === d, "R7 handler pc", newpc_o, d);
        chk(sr_o === x[15:0], "R7 handler sr", sr_o, x);
        chk(sp_o === y, "R7 final sp", sp_o, y);
      end
    end else begin
      chk(!mem_wr_o && !mem_rd_o && !newpc_valid_o && !halt_o,
          "R11 quiet outside sequence", {mem_wr_o, mem_rd_o, newpc_valid_o, halt_o}, 0);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_cycle();
  endtask

  // Model: evaluate the driven fault, check abort, queue the expected cycles.
  task automatic fire(string tag);
    logic odd_hit, err; int vec; logic [31:0] spc, s, info, base;
    #1;
    odd_hit = acc_valid && acc_addr[0] && (acc_wide || acc_fetch);
    err = odd_hit || bus_err;
    chk(abort_o === err, tag, abort_o, err);
    if (err) begin
      if (act == 2'd1 || ssp[0]) pend = 1;
      else begin
        vec  = odd_hit ? 3 : 2;
        base = vec * 4;
        spc  = exc_last ? exc_vec : pc + pc_off;
        info = acc_read * 16 + ((act == 2'd2) ? 8 : 0) + acc_fc;
        s = ssp;
        expect_ev(0, s - 2,  spc % 65536, 0, 0, "R6 saved pc low");
        expect_ev(0, s - 4,  spc / 65536, 0, 0, "R6 saved pc high");
        expect_ev(0, s - 6,  sr, 0, 0, "R3 entry sr");
        expect_ev(0, s - 8,  ir, 0, 0, "R3 instruction word");
        expect_ev(0, s - 10, acc_addr % 65536, 0, 0, "R3 fault addr low");
        expect_ev(0, s - 12, acc_addr / 65536, 0, 0, "R3 fault addr high");
        expect_ev(0, s - 14, info, 0, 0, (act == 2'd2) ? "R5 info flag" : "R4 info word");
        expect_ev(1, base, 0, 0, 0, odd_hit ? "R8 vector high read" : "R7 vector high read");
        expect_ev(1, base + 2, 0, 0, 0, "R7 vector low read");
        expect_ev(2, 0, {table_word(base), table_word(base + 2)},
                  (sr & 16'h7FFF) | 16'h2000, s - 14, "R7");
      end
    end
    step();
    bus_err = 0; acc_valid = 0;
  endtask

  task automatic set_acc(logic [31:0] a, logic wide, logic fetch, logic rd, logic [2:0] fc);
    acc_valid = 1; acc_addr = a; acc_wide = wide; acc_fetch = fetch;
    acc_read = rd; acc_fc = fc;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    exp_halt = 0; pend = 0;
    kq.delete(); aq.delete(); dq.delete(); xq.delete(); yq.delete(); tq.delete();
    rst_n = 1;
    #1;
    chk(halt_o === 0 && busy_o === 0 && mem_wr_o === 0, "R9 released by reset",
        {halt_o, busy_o, mem_wr_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    ssp = 32'h0000_1000; pc = 32'h0001_2340; pc_off = 4'd4;
    sr = 16'h8704; ir = 16'h4E71; exc_vec = 32'h78;
    do_reset();
    drain(2);
    // R1: odd byte read, no fault
    set_acc(32'h0000_2001, 0, 0, 1, 3'd5); fire("R1 odd byte ignored"); drain(2);
    // R1: even word, no fault
    set_acc(32'h0000_2002, 1, 0, 1, 3'd5); fire("R1 even word ignored"); drain(2);
    // bus error, normal activity, read
    act = 2'd0; set_acc(32'h00AB_2002, 1, 0, 1, 3'd5); bus_err = 1;
    fire("R2 bus error abort"); drain(11);
    // R1: odd word write, group 2 activity
    act = 2'd3; ssp = 32'h0000_0F00; sr = 16'h0011;
    set_acc(32'h0012_3457, 1, 0, 0, 3'd1); fire("R1 odd word write"); drain(11);
    // R1: odd fetch with R5 group 1 flag
    act = 2'd2; pc_off = 4'd10; set_acc(32'h0000_4443, 0, 1, 1, 3'd6);
    fire("R1 odd fetch"); drain(11);
    // R6: fault during last step of another exception
    act = 2'd3; exc_last = 1; set_acc(32'h0000_0078, 1, 0, 1, 3'd7); bus_err = 1;
    fire("R6 last-step fault"); exc_last = 0; drain(11);
    // R8: bus error and odd word together
    act = 2'd0; set_acc(32'h0000_3335, 1, 0, 1, 3'd2); bus_err = 1;
    fire("R8 both faults"); drain(2);
    // R11: odd access during busy is ignored
    set_acc(32'h0000_5555, 1, 1, 1, 3'd2); #1;
    chk(abort_o === 0, "R11 busy ignores access", abort_o, 0);
    step(); step(); acc_valid = 0; drain(8);
    // R9: group 0 activity -> halt
    act = 2'd1; set_acc(32'h0000_1000, 1, 0, 1, 3'd5); bus_err = 1;
    fire("R9 group0 fault"); drain(4);
    do_reset(); drain(1);
    // R9: bus error on own stack write -> halt
    act = 2'd0; set_acc(32'h0000_2000, 1, 0, 1, 3'd5); bus_err = 1;
    fire("R2 start"); drain(2);
    bus_err = 1; #1;
    chk(abort_o === 1, "R2 abort on own access", abort_o, 1);
    pend = 1; step(); bus_err = 0; drain(4);
    do_reset(); drain(1);
    // R10: odd stack pointer -> halt
    ssp = 32'h0000_0FFF; set_acc(32'h0000_2000, 1, 0, 1, 3'd5); bus_err = 1;
    fire("R10 odd stack"); drain(3);
    do_reset(); drain(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule